// File: doc/BRIEF.md
# Run-Time Selectable Word Delay Line

This block delays a 16-bit data word by a number of clock cycles that is chosen while the design runs. The depth is set by an 8-bit unsigned delay input. The storage is built once, at the largest delay the block supports. Every stored word moves one place down a fixed register chain on every clock. A selector then chooses which point of the chain feeds the registered output.

A user drives a new word on every cycle and sets the delay input. The word comes back out after that many clock edges. The delay can change at any time. The output switches straight to the newly chosen point of the chain on the next edge. The chain is not drained or refilled, so history that is already stored appears at the output at once.

Top module: `dly_line_var`

## Requirements
- R1: While `rst_n` is low at a rising edge, every stored word and `dout` become 0. After release, `dout` shows 0 until the first word sampled after reset has passed through the chosen delay.
- R2: With a delay setting N in 1..64, `dout` after rising edge t equals the `din` value sampled at rising edge t−N+1. The output register counts as one of the N cycles, so N=1 gives `din` of the same edge.
- R3: A delay setting of 0 behaves exactly as a setting of 1.
- R4: Any delay setting from 65 to 255 behaves exactly as a setting of 64.
- R5: A change of the delay setting takes effect at the next rising edge. `dout` then shows the word stored at the new depth, with no flush and no refill gap.
- R6: All 16 data bits travel through the delay unchanged. This includes all-ones, all-zeros and alternating patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 16 | Data word sampled on every rising edge |
| dly_cfg | input | 8 | Requested delay in cycles, unsigned; 0 reads as 1, above 64 reads as 64 |
| dout | output | 16 | Registered delayed data word |

## Verification
A table walks settings 0, 1, 2, 17, 63, 64, 65, 200 and 255 in turn over a stream of changing words. Each setting is checked against the bench's own history at the delay the table states. The out-of-range and zero rows separate correct clamping from wrap-around or truncation of the setting. The 63, 64 and 65 rows expose off-by-one errors at the top of the chain. A directed reset with the delay at maximum shows that the full chain was cleared and not just the output. A one-cycle switch of the setting from 64 to 5 and back tells an immediate tap change apart from a change that waits for a refill. Data patterns of all-ones, all-zeros and alternating bits catch lost or swapped bits.

// File: rtl/dly_pkg.sv
// Package: shared sizing for the run-time selectable delay line.
// Assumes the largest delay fits in the unsigned setting field.
package dly_pkg;
    localparam int unsigned DATA_W    = 16;   // width of the delayed word
    localparam int unsigned MAX_DEPTH = 64;   // largest selectable delay in cycles
    localparam int unsigned CFG_W     = 8;    // width of the delay setting

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dly_sel_clamp.sv
// Module: dly_sel_clamp
// Turns the raw delay setting into a zero-based tap index.
// Assumes: the chain supports delays 1..MAX_DEPTH and MAX_DEPTH < 2**CFG_W.
// Setting 0 maps to index 0 (delay 1); settings above MAX_DEPTH map to the
// last index (delay MAX_DEPTH). Purely combinational.
module dly_sel_clamp #(
    parameter int unsigned CFG_W     = 8,
    parameter int unsigned MAX_DEPTH = 64,
    localparam int unsigned IDX_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1
) (
    input  logic [CFG_W-1:0] cfg_raw,
    output logic [IDX_W-1:0] tap_idx
);
    localparam logic [CFG_W-1:0] CFG_MAX = CFG_W'(MAX_DEPTH);

    // Clamp the setting into 1..MAX_DEPTH and subtract one.
    always_comb begin
        if (cfg_raw == '0) begin
            tap_idx = '0;
        end else if (cfg_raw > CFG_MAX) begin
            tap_idx = IDX_W'(MAX_DEPTH - 1);
        end else begin
            tap_idx = IDX_W'(cfg_raw - CFG_W'(1));
        end
    end
endmodule

// File: rtl/dly_shift_chain.sv
// Module: dly_shift_chain
// Fixed-length register chain. Stage 0 samples the input word and each later
// stage samples its predecessor on every rising edge, whatever the selected
// delay is. Assumes: STAGES >= 1; synchronous active-low reset clears all.
module dly_shift_chain #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAGES = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] stage_q [STAGES]
);
    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_head
                // Capture the incoming word into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= word_in;
                end

                p_head_capture_r2: assert property (@(posedge clk)
                    disable iff (!rst_n)
                    $past(rst_n) |-> stage_q[0] == $past(word_in))
                    else $error("first stage missed the input word");
            end else begin : g_body
                // Move the previous stage's word one place down.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[k] <= '0;
                    else        stage_q[k] <= stage_q[k-1];
                end

                p_shift_step_r6: assert property (@(posedge clk)
                    disable iff (!rst_n)
                    $past(rst_n) |-> stage_q[k] == $past(stage_q[k-1]))
                    else $error("chain stage did not take its predecessor");
            end
        end
    endgenerate
endmodule

// File: rtl/dly_tap_mux.sv
// Module: dly_tap_mux
// Chooses the word that the output register loads. Index 0 selects the live
// input (delay 1); index k selects chain stage k-1 (delay k+1).
// Assumes: the index never exceeds STAGES (the clamp guarantees it);
// unused power-of-two slots read as zero.
module dly_tap_mux #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned STAGES = 63,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [DATA_W-1:0] stage_q [STAGES],
    input  logic [IDX_W-1:0]  tap_idx,
    output logic [DATA_W-1:0] tap_word
);
    localparam int unsigned SLOTS = 2 ** IDX_W;

    logic [DATA_W-1:0] taps [SLOTS];

    genvar s;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_tap
            if (s == 0) begin : g_live
                assign taps[s] = word_in;
            end else if (s <= STAGES) begin : g_reg
                assign taps[s] = stage_q[s-1];
            end else begin : g_pad
                assign taps[s] = '0;
            end
        end
    endgenerate

    // Pick the tap named by the clamped index.
    always_comb tap_word = taps[tap_idx];
endmodule

// File: rtl/dly_line_var.sv
// Module: dly_line_var (top)
// Delays a data word by 1..MAX_DEPTH cycles, chosen at run time by dly_cfg.
// The storage is a fixed chain of MAX_DEPTH-1 registers plus one output
// register, so the longest path through storage is MAX_DEPTH edges.
// Assumes: synchronous active-low reset; the setting may change on any cycle.
module dly_line_var
    import dly_pkg::*;
#(
    parameter int unsigned P_DATA_W    = DATA_W,
    parameter int unsigned P_MAX_DEPTH = MAX_DEPTH,
    parameter int unsigned P_CFG_W     = CFG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_DATA_W-1:0] din,
    input  logic [P_CFG_W-1:0]  dly_cfg,
    output logic [P_DATA_W-1:0] dout
);
    localparam int unsigned STAGES = (P_MAX_DEPTH > 1) ? P_MAX_DEPTH - 1 : 1;
    localparam int unsigned IDX_W  = (P_MAX_DEPTH > 1) ? $clog2(P_MAX_DEPTH) : 1;
    localparam logic [P_CFG_W-1:0] CFG_TOP = P_CFG_W'(P_MAX_DEPTH);

    logic [IDX_W-1:0]    tap_idx;
    logic [P_DATA_W-1:0] stage_q [STAGES];
    logic [P_DATA_W-1:0] tap_word;

    dly_sel_clamp #(
        .CFG_W     (P_CFG_W),
        .MAX_DEPTH (P_MAX_DEPTH)
    ) u_clamp (
        .cfg_raw (dly_cfg),
        .tap_idx (tap_idx)
    );

    dly_shift_chain #(
        .DATA_W (P_DATA_W),
        .STAGES (STAGES)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (din),
        .stage_q (stage_q)
    );

    dly_tap_mux #(
        .DATA_W (P_DATA_W),
        .STAGES (STAGES),
        .IDX_W  (IDX_W)
    ) u_mux (
        .word_in  (din),
        .stage_q  (stage_q),
        .tap_idx  (tap_idx),
        .tap_word (tap_word)
    );

    // Register the selected tap; this register is the last delay cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= tap_word;
    end

    // R1: one edge after reset is held, the output is zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> dout == '0)
        else $error("output not cleared by reset");

    // R2/R3: settings 0 and 1 both pass the input with a single-edge delay.
    p_short_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dly_cfg) <= P_CFG_W'(1)) |-> dout == $past(din))
        else $error("setting 0/1 did not give a one-cycle delay");

    // R4: any setting at or above the top takes the last chain stage.
    p_top_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dly_cfg) >= CFG_TOP)
            |-> dout == $past(stage_q[STAGES-1]))
        else $error("large setting not clamped to the deepest tap");

    // R5: the output follows the tap chosen at the previous edge, no refill.
    p_tap_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dly_cfg) == P_CFG_W'(2) && P_MAX_DEPTH > 1)
            |-> dout == $past(stage_q[0]))
        else $error("setting 2 did not pick the first chain stage");
endmodule

// File: tb/dly_line_var_test.sv
`timescale 1ns/1ps
module dly_line_var_test;
    localparam int unsigned DW = 16;
    localparam int unsigned CW = 8;
    localparam int unsigned HIST = 128;
    localparam int unsigned VEC_N = 9;
    localparam int unsigned RUN_LEN = 70;

    // Stimulus setting and the delay the requirements say it must give.
    localparam logic [CW-1:0] VEC_CFG [VEC_N] = '{8'd0, 8'd1, 8'd2, 8'd17, 8'd63,
                                                  8'd64, 8'd65, 8'd200, 8'd255};
    localparam int unsigned VEC_EXP [VEC_N] = '{1, 1, 2, 17, 63, 64, 64, 64, 64};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [CW-1:0] dly_cfg = 8'd1;
    logic [DW-1:0] dout;

    logic [DW-1:0] hist [HIST];
    int checks = 0;
    int fails  = 0;
    int seq    = 0;

    dly_line_var uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .dly_cfg (dly_cfg),
        .dout    (dout)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [DW-1:0] exp, input string req);
        checks++;
        if (dout !== exp) begin
            fails++;
            $display("FAIL %s: dout=%h expected=%h", req, dout, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int n);
        case (n % 7)
            0: return 16'hFFFF;
            1: return 16'h0000;
            2: return 16'hA5A5;
            3: return 16'h5A5A;
            default: return 16'((n * 16'h1357) ^ 16'hC3E1);
        endcase
    endfunction

    // Drive one word and setting, clock it in, record history, then check.
    task automatic cycle(input logic [DW-1:0] d, input logic [CW-1:0] c,
                         input int unsigned exp_n, input string req);
        din = d;
        dly_cfg = c;
        @(posedge clk);
        for (int i = HIST - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
        @(negedge clk);
        check(hist[exp_n-1], req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din = 16'hDEAD;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < HIST; i++) hist[i] = '0;
        check('0, "R1 reset state");
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Table walk: R2 depths, R3 zero setting, R4 clamping, R6 data patterns.
        for (int v = 0; v < VEC_N; v++) begin
            for (int c = 0; c < RUN_LEN; c++) begin
                cycle(pattern(seq), VEC_CFG[v], VEC_EXP[v], "R2/R3/R4/R6 table");
                seq++;
            end
        end

        // R1: reset with the deepest delay; zeros must come out for 63 edges.
        do_reset();
        for (int c = 0; c < 63; c++) begin
            cycle(16'hFFFF - 16'(c), 8'd64, 64, "R1 cleared chain");
        end
        cycle(16'h1234, 8'd64, 64, "R1 first word arrives");
        check(16'hFFFF, "R1 first post-reset word");

        // R5: switch 64 -> 5 for one cycle and back, no refill gap.
        for (int c = 0; c < 10; c++) begin
            cycle(pattern(seq), 8'd64, 64, "R5 fill");
            seq++;
        end
        cycle(16'h0F0F, 8'd5, 5, "R5 switch down");
        cycle(16'hF0F0, 8'd64, 64, "R5 switch back");
        cycle(16'h3C3C, 8'd1, 1, "R5 switch to shortest");
        cycle(16'hC3C3, 8'd255, 64, "R5 jump to clamped top");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule